// File: doc/BRIEF.md
# Byte-Wide Packet Channel Port

This block is one end of a point-to-point link that moves packets a byte at a time over a single shared byte lane. Both ends use the same lane for both directions, so only one packet is on the link at a time. Next to the eight data lines there is a parity line. There are also two handshake lines: a request that the sending end raises while its byte is valid, and a ready that the receiving end raises while it can take a byte. A byte moves on a clock edge only when both lines are high. Each line is split at the port boundary into an output and an input half. The data lane also has an output enable.

The user side has a byte transmit stream (valid/ready) and a byte receive stream that marks the first and last byte of each packet. It also flags a parity error on the last byte. The port needs no length sideband. It works out where each packet ends from its leading command byte, and it does this the same way when sending and when receiving. A parameter sets the port's role. When both ends start a packet in the same cycle, the upstream end keeps the link. The downstream end backs off and sends again after that packet.

Top module: `bytechan_port`

## Requirements
- R1: While reset is held, the port drives request, ready, output enable, rx_valid and tx_ready low.
- R2: Whenever the port requests, the nine bits made of ch_data_o and ch_par_o hold an odd number of ones.
- R3: A byte leaves the transmit stream only on an edge where the port requests and the peer's ready is high. While the peer's ready is low, tx_ready stays low and the offered byte stays on the lane.
- R4: The port raises ready only while receiving and while its receive holding register is empty or being read in the same cycle. With a full register and rx_ready low, ready is low.
- R5: Packet length follows from the command byte. Bit 7 set means a size byte follows. Bit 6 set means ADDR_BYTES (default 4) address bytes follow. When the size byte is present, that many data bytes (0 to 255) come last. The byte order is command, size, address, data.
- R6: Received bytes reach rx_data in lane order, unchanged. rx_first marks the command byte and rx_last marks the final byte that R5 gives.
- R7: If any byte of a packet arrives with even parity, rx_perr is set together with rx_last of that packet. Every byte is still delivered, and the next packet starts with no error.
- R8: The port never requests and signals ready in the same cycle. A port that sees the peer's request while idle turns to receive and does not request until that packet has ended.
- R9: When both ports start requesting in the same cycle, the downstream port drops its request one cycle later and receives. The upstream port keeps its request. The downstream packet goes out after the upstream packet's last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | DW | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken on this edge when valid |
| rx_valid | output | 1 | Received byte held |
| rx_data | output | DW | Received byte |
| rx_first | output | 1 | Held byte is a command byte |
| rx_last | output | 1 | Held byte ends its packet |
| rx_perr | output | 1 | Parity error somewhere in the packet (with rx_last) |
| rx_ready | input | 1 | User takes the held byte |
| ch_data_o | output | DW | Lane data driven by this port |
| ch_par_o | output | 1 | Odd parity of ch_data_o |
| ch_oe_o | output | 1 | This port owns the lane |
| ch_req_o | output | 1 | Request: this port's byte is valid |
| ch_rdy_o | output | 1 | Ready: this port can take a byte |
| ch_data_i | input | DW | Lane data from the peer |
| ch_par_i | input | 1 | Parity from the peer |
| ch_req_i | input | 1 | Peer's request |
| ch_rdy_i | input | 1 | Peer's ready |

## Verification
Two ports, one of each role, are wired back to back. Packets of every shape go through the link in both directions: command only, size with no data, size with data, address only, address with size, and a long data run. Together these set apart every branch of the length decode. Stalling the receiver shows whether the sender holds its byte and the receiver's ready drops, and a flipped parity line shows whether the error is reported on the last byte and cleared afterward. Starts that coincide and starts that are one cycle apart separate collision resolution from simply deferring to an earlier requester.

// File: rtl/bytechan_pkg.sv
package bytechan_pkg;
    typedef enum logic [1:0] {PS_IDLE, PS_TX, PS_RX} port_st_e;
    typedef enum logic [1:0] {PH_CMD, PH_SIZE, PH_ADDR, PH_DATA} phase_e;
    localparam int CMD_SIZE_BIT = 7;
    localparam int CMD_ADDR_BIT = 6;
endpackage

// File: rtl/bytechan_parser.sv
// Tracks packet position from the command byte; shared by both directions.
module bytechan_parser
    import bytechan_pkg::*;
#(
    parameter int DW         = 8,
    parameter int ADDR_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] byte_i,
    output logic          at_cmd,
    output logic          is_last
);
    localparam logic [DW-1:0] ADDR_LAST = DW'(ADDR_BYTES - 1);

    typedef struct packed {
        phase_e        ph;
        logic          has_addr;
        logic [DW-1:0] sz;
        logic [DW-1:0] cnt;
    } prs_t;

    prs_t q, d;

    always_comb begin
        d       = q;
        is_last = 1'b0;
        unique case (q.ph)
            PH_CMD: begin
                is_last = !byte_i[CMD_SIZE_BIT] && !byte_i[CMD_ADDR_BIT];
                if (take) begin
                    d.has_addr = byte_i[CMD_ADDR_BIT];
                    d.sz       = '0;
                    if (byte_i[CMD_SIZE_BIT]) begin
                        d.ph = PH_SIZE;
                    end else if (byte_i[CMD_ADDR_BIT]) begin
                        d.ph  = PH_ADDR;
                        d.cnt = ADDR_LAST;
                    end
                end
            end
            PH_SIZE: begin
                is_last = !q.has_addr && (byte_i == '0);
                if (take) begin
                    d.sz = byte_i;
                    if (q.has_addr) begin
                        d.ph  = PH_ADDR;
                        d.cnt = ADDR_LAST;
                    end else if (byte_i == '0) begin
                        d.ph = PH_CMD;
                    end else begin
                        d.ph  = PH_DATA;
                        d.cnt = byte_i - 1'b1;
                    end
                end
            end
            PH_ADDR: begin
                is_last = (q.cnt == '0) && (q.sz == '0);
                if (take) begin
                    if (q.cnt != '0) begin
                        d.cnt = q.cnt - 1'b1;
                    end else if (q.sz == '0) begin
                        d.ph = PH_CMD;
                    end else begin
                        d.ph  = PH_DATA;
                        d.cnt = q.sz - 1'b1;
                    end
                end
            end
            default: begin
                is_last = (q.cnt == '0);
                if (take) begin
                    if (q.cnt == '0) d.ph = PH_CMD;
                    else             d.cnt = q.cnt - 1'b1;
                end
            end
        endcase
    end

    assign at_cmd = (q.ph == PH_CMD);

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{ph: PH_CMD, has_addr: 1'b0, sz: '0, cnt: '0};
        else        q <= d;
    end
endmodule

// File: rtl/bytechan_rxhold.sv
// One-entry receive holding register with packet markers.
module bytechan_rxhold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] in_data,
    input  logic          in_first,
    input  logic          in_last,
    input  logic          in_perr,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_first,
    output logic          out_last,
    output logic          out_perr,
    output logic          can_load
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] data;
        logic          first;
        logic          last;
        logic          perr;
    } hold_t;

    hold_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d = '{v: 1'b1, data: in_data, first: in_first, last: in_last, perr: in_perr};
        end else if (out_ready) begin
            d.v = 1'b0;
        end
    end

    assign can_load  = !q.v || out_ready;
    assign out_valid = q.v;
    assign out_data  = q.data;
    assign out_first = q.first;
    assign out_last  = q.last;
    assign out_perr  = q.perr;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/bytechan_port.sv
module bytechan_port
    import bytechan_pkg::*;
#(
    parameter bit IS_UP      = 1'b1,
    parameter int DW         = 8,
    parameter int ADDR_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_ready,
    output logic          rx_valid,
    output logic [DW-1:0] rx_data,
    output logic          rx_first,
    output logic          rx_last,
    output logic          rx_perr,
    input  logic          rx_ready,
    output logic [DW-1:0] ch_data_o,
    output logic          ch_par_o,
    output logic          ch_oe_o,
    output logic          ch_req_o,
    output logic          ch_rdy_o,
    input  logic [DW-1:0] ch_data_i,
    input  logic          ch_par_i,
    input  logic          ch_req_i,
    input  logic          ch_rdy_i
);
    typedef struct packed {
        port_st_e st;
        logic     perr_acc;
    } port_t;

    port_t q, d;

    logic          in_tx, in_rx, tx_fire, rx_fire, can_load;
    logic          p_take, p_at_cmd, p_last, byte_err, withdraw, ld_perr;
    logic [DW-1:0] p_byte;

    assign in_tx    = (q.st == PS_TX);
    assign in_rx    = (q.st == PS_RX);
    assign ch_req_o = in_tx && tx_valid;
    assign ch_oe_o  = in_tx;
    assign ch_data_o = tx_data;
    assign ch_par_o = ~^tx_data;
    assign tx_ready = in_tx && ch_rdy_i;
    assign tx_fire  = ch_req_o && ch_rdy_i;
    assign ch_rdy_o = in_rx && can_load;
    assign rx_fire  = ch_rdy_o && ch_req_i;
    assign byte_err = ~(^{ch_data_i, ch_par_i});
    assign p_take   = tx_fire || rx_fire;
    assign p_byte   = in_tx ? tx_data : ch_data_i;
    assign withdraw = !IS_UP && in_tx && ch_req_i && p_at_cmd;
    assign ld_perr  = p_last && (q.perr_acc || byte_err);

    bytechan_parser #(.DW(DW), .ADDR_BYTES(ADDR_BYTES)) parser_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (p_take),
        .byte_i (p_byte),
        .at_cmd (p_at_cmd),
        .is_last(p_last)
    );

    bytechan_rxhold #(.DW(DW)) hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rx_fire),
        .in_data  (ch_data_i),
        .in_first (p_at_cmd),
        .in_last  (p_last),
        .in_perr  (ld_perr),
        .out_ready(rx_ready),
        .out_valid(rx_valid),
        .out_data (rx_data),
        .out_first(rx_first),
        .out_last (rx_last),
        .out_perr (rx_perr),
        .can_load (can_load)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            PS_IDLE: begin
                if (ch_req_i)      d.st = PS_RX;
                else if (tx_valid) d.st = PS_TX;
            end
            PS_TX: begin
                if (withdraw)                d.st = PS_RX;
                else if (tx_fire && p_last)  d.st = PS_IDLE;
            end
            default: begin
                if (rx_fire && p_last) d.st = PS_IDLE;
            end
        endcase
        if (rx_fire) d.perr_acc = p_last ? 1'b0 : (q.perr_acc || byte_err);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: PS_IDLE, perr_acc: 1'b0};
        else        q <= d;
    end
endmodule

// File: rtl/bytechan_port_chk.sv
module bytechan_port_chk #(
    parameter bit IS_UP = 1'b1,
    parameter int DW    = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ch_req_o,
    input logic          ch_rdy_o,
    input logic          ch_req_i,
    input logic [DW-1:0] ch_data_o,
    input logic          ch_par_o,
    input logic          rx_valid,
    input logic          rx_ready,
    input logic [DW-1:0] rx_data,
    input logic          rx_last,
    input logic          rx_perr
);
    a_r8_no_req_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        !(ch_req_o && ch_rdy_o));

    a_r8_start_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_req_o) |-> !$past(ch_req_i));

    a_r2_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        ch_req_o |-> (^{ch_data_o, ch_par_o}) == 1'b1);

    a_r4_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r7_perr_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_perr) |-> rx_last);

    generate
        if (!IS_UP) begin : g_down
            a_r9_down_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
                (ch_req_o && ch_req_i) |=> !ch_req_o);
        end
    endgenerate
endmodule

bind bytechan_port bytechan_port_chk #(.IS_UP(IS_UP), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_req_o (ch_req_o),
    .ch_rdy_o (ch_rdy_o),
    .ch_req_i (ch_req_i),
    .ch_data_o(ch_data_o),
    .ch_par_o (ch_par_o),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .rx_last  (rx_last),
    .rx_perr  (rx_perr)
);

// File: tb/bytechan_port_tb_top.sv
`timescale 1ns/100ps
module bytechan_port_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // upstream side (dut_i) and downstream side (peer_i)
    logic       u_tx_valid, u_tx_ready, u_rx_valid, u_rx_first, u_rx_last, u_rx_perr, u_rx_ready;
    logic [7:0] u_tx_data, u_rx_data, u_data_o;
    logic       u_par_o, u_oe_o, u_req_o, u_rdy_o;
    logic       d_tx_valid, d_tx_ready, d_rx_valid, d_rx_first, d_rx_last, d_rx_perr, d_rx_ready;
    logic [7:0] d_tx_data, d_rx_data, d_data_o;
    logic       d_par_o, d_oe_o, d_req_o, d_rdy_o;
    logic       flip_par;

    bytechan_port #(.IS_UP(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(u_tx_valid), .tx_data(u_tx_data), .tx_ready(u_tx_ready),
        .rx_valid(u_rx_valid), .rx_data(u_rx_data), .rx_first(u_rx_first),
        .rx_last(u_rx_last), .rx_perr(u_rx_perr), .rx_ready(u_rx_ready),
        .ch_data_o(u_data_o), .ch_par_o(u_par_o), .ch_oe_o(u_oe_o),
        .ch_req_o(u_req_o), .ch_rdy_o(u_rdy_o),
        .ch_data_i(d_data_o), .ch_par_i(d_par_o), .ch_req_i(d_req_o), .ch_rdy_i(d_rdy_o)
    );

    bytechan_port #(.IS_UP(1'b0)) peer_i (
        .clk(clk), .rst_n(rst_n),
        .tx_valid(d_tx_valid), .tx_data(d_tx_data), .tx_ready(d_tx_ready),
        .rx_valid(d_rx_valid), .rx_data(d_rx_data), .rx_first(d_rx_first),
        .rx_last(d_rx_last), .rx_perr(d_rx_perr), .rx_ready(d_rx_ready),
        .ch_data_o(d_data_o), .ch_par_o(d_par_o), .ch_oe_o(d_oe_o),
        .ch_req_o(d_req_o), .ch_rdy_o(d_rdy_o),
        .ch_data_i(u_data_o), .ch_par_i(u_par_o ^ flip_par), .ch_req_i(u_req_o), .ch_rdy_i(u_rdy_o)
    );

    int  n_cmp = 0;
    int  n_mis = 0;
    logic [10:0] q_to_dn[$];
    logic [10:0] q_to_up[$];
    time t_dn_first, t_dn_last, t_up_first, t_up_last;
    bit  toggling;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: builds the packet per R5, queues expected items, then drives it.
    task automatic send(input bit up, input logic [7:0] cmd, input logic [7:0] sz, input bit bad);
        logic [7:0] b[$];
        int n;
        b.push_back(cmd);
        if (cmd[7]) b.push_back(sz);
        if (cmd[6]) for (int a = 0; a < 4; a++) b.push_back(8'hA0 + 8'(a) + cmd);
        if (cmd[7]) for (int i = 0; i < int'(sz); i++) b.push_back(cmd ^ 8'(i * 7 + 1));
        n = b.size();
        for (int i = 0; i < n; i++) begin
            if (up) q_to_dn.push_back({bad && (i == n - 1), i == n - 1, i == 0, b[i]});
            else    q_to_up.push_back({1'b0, i == n - 1, i == 0, b[i]});
        end
        if (up) flip_par = bad;
        for (int i = 0; i < n; i++) begin
            if (up) begin u_tx_valid = 1'b1; u_tx_data = b[i]; end
            else    begin d_tx_valid = 1'b1; d_tx_data = b[i]; end
            #1;
            while (!(up ? u_tx_ready : d_tx_ready)) begin
                @(negedge clk); #1;
            end
            @(negedge clk);
        end
        if (up) begin u_tx_valid = 1'b0; flip_par = 1'b0; end
        else    d_tx_valid = 1'b0;
    endtask

    // Monitors: pop the scoreboard as the design hands out bytes (R5, R6, R7).
    initial forever begin
        @(negedge clk); #1;
        if (rst_n && d_rx_valid && d_rx_ready) begin
            if (q_to_dn.size() == 0) chk(1'b0, "R6 unexpected byte at downstream", {24'd0, d_rx_data}, 0);
            else begin
                logic [10:0] e;
                e = q_to_dn.pop_front();
                chk({d_rx_last, d_rx_first, d_rx_data} == e[9:0], "R5,R6 downstream byte",
                    {22'd0, d_rx_last, d_rx_first, d_rx_data}, {22'd0, e[9:0]});
                chk(d_rx_perr == e[10], "R7 downstream perr", {31'd0, d_rx_perr}, {31'd0, e[10]});
            end
            if (d_rx_first) t_dn_first = $time;
            if (d_rx_last)  t_dn_last  = $time;
        end
    end

    initial forever begin
        @(negedge clk); #1;
        if (rst_n && u_rx_valid && u_rx_ready) begin
            if (q_to_up.size() == 0) chk(1'b0, "R6 unexpected byte at upstream", {24'd0, u_rx_data}, 0);
            else begin
                logic [10:0] e;
                e = q_to_up.pop_front();
                chk({u_rx_last, u_rx_first, u_rx_data} == e[9:0], "R5,R6 upstream byte",
                    {22'd0, u_rx_last, u_rx_first, u_rx_data}, {22'd0, e[9:0]});
                chk(u_rx_perr == e[10], "R7 upstream perr", {31'd0, u_rx_perr}, {31'd0, e[10]});
            end
            if (u_rx_first) t_up_first = $time;
            if (u_rx_last)  t_up_last  = $time;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_mis++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        logic [7:0] held;
        u_tx_valid = 0; u_tx_data = 0; u_rx_ready = 1;
        d_tx_valid = 0; d_tx_data = 0; d_rx_ready = 1;
        flip_par = 0; toggling = 0;
        repeat (3) @(negedge clk);
        #2;
        // R1: reset state
        chk({u_req_o, u_rdy_o, u_oe_o, u_rx_valid, u_tx_ready} == 5'b0, "R1 upstream reset outputs",
            {27'd0, u_req_o, u_rdy_o, u_oe_o, u_rx_valid, u_tx_ready}, 0);
        chk({d_req_o, d_rdy_o, d_oe_o, d_rx_valid, d_tx_ready} == 5'b0, "R1 downstream reset outputs",
            {27'd0, d_req_o, d_rdy_o, d_oe_o, d_rx_valid, d_tx_ready}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);

        // R5/R6: every packet shape, both directions
        send(1, 8'h05, 8'd0, 0);
        send(1, 8'h83, 8'd3, 0);
        send(1, 8'h41, 8'd0, 0);
        send(1, 8'hC2, 8'd2, 0);
        send(1, 8'hC0, 8'd0, 0);
        send(1, 8'h80, 8'd0, 0);
        send(0, 8'h9A, 8'd5, 0);
        send(0, 8'h01, 8'd0, 0);
        send(0, 8'h47, 8'd0, 0);

        // R3/R4/R2: receiver stalls
        d_rx_ready = 1'b0;
        fork
            send(1, 8'h84, 8'd6, 0);
            begin
                repeat (5) @(negedge clk);
                #2;
                chk(u_req_o == 1'b1, "R3 sender keeps request while stalled", {31'd0, u_req_o}, 1);
                chk(u_tx_ready == 1'b0, "R3 tx_ready low while peer not ready", {31'd0, u_tx_ready}, 0);
                chk(d_rdy_o == 1'b0, "R4 ready low with full holding register", {31'd0, d_rdy_o}, 0);
                chk((^{u_data_o, u_par_o}) == 1'b1, "R2 odd parity on lane", {23'd0, u_par_o, u_data_o}, 1);
                held = u_data_o;
                @(negedge clk); #2;
                chk(u_data_o == held, "R3 byte held on lane", {24'd0, u_data_o}, {24'd0, held});
                @(negedge clk);
                d_rx_ready = 1'b1;
            end
        join
        repeat (4) @(negedge clk);

        // R7: bad parity over one packet, then a clean one
        send(1, 8'h82, 8'd2, 1);
        send(1, 8'h81, 8'd1, 0);
        repeat (4) @(negedge clk);

        // R8: downstream requests first; upstream must defer
        t_up_last = 0; t_dn_first = 0;
        fork
            send(0, 8'h83, 8'd3, 0);
            begin @(negedge clk); send(1, 8'h02, 8'd0, 0); end
            begin
                @(negedge clk); @(negedge clk); #2;
                chk(u_req_o == 1'b0, "R8 no request while peer holds the lane", {31'd0, u_req_o}, 0);
                chk(u_rdy_o == 1'b1, "R8 idle port turns to receive", {31'd0, u_rdy_o}, 1);
            end
        join
        repeat (4) @(negedge clk);
        chk(t_dn_first > t_up_last, "R8 deferred packet follows peer packet",
            32'(t_dn_first), 32'(t_up_last));

        // R9: simultaneous start
        t_dn_last = 0; t_up_first = 0;
        fork
            send(1, 8'h83, 8'd3, 0);
            send(0, 8'h41, 8'd0, 0);
            begin
                @(negedge clk); #2;
                chk(u_req_o && d_req_o, "R9 both request in the same cycle", {30'd0, u_req_o, d_req_o}, 3);
                @(negedge clk); #2;
                chk(!d_req_o && u_req_o, "R9 downstream withdraws, upstream keeps",
                    {30'd0, u_req_o, d_req_o}, 2);
            end
        join
        repeat (4) @(negedge clk);
        chk(t_up_first > t_dn_last, "R9 downstream packet after upstream last byte",
            32'(t_up_first), 32'(t_dn_last));

        // R5/R6: long packet with a toggling consumer
        toggling = 1'b1;
        fork
            begin send(0, 8'h80, 8'd200, 0); toggling = 1'b0; end
            while (toggling) begin @(negedge clk); u_rx_ready = ~u_rx_ready; end
        join
        u_rx_ready = 1'b1;

        repeat (20) @(negedge clk);
        chk(q_to_dn.size() == 0, "R6 all bytes reached downstream", q_to_dn.size(), 0);
        chk(q_to_up.size() == 0, "R6 all bytes reached upstream", q_to_up.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule